// File: doc/BRIEF.md
# Swept-Filter Scan and Sample-Quench Sequencer

This block produces the timing for a swept-filter spectrum readout that runs beside a recirculating sample memory. It counts the fast clock in frames of fixed length, each frame matching one full pass of the memory. By default a frame is 600 cycles, which is 300 microseconds at 2 MHz. Most of the frame is integration time. On the last integration cycle the block raises a one-cycle sample strobe, which tells the analog hold stage to capture the resonant integrator. It then holds a quench strobe for a fixed number of cycles so that the integrator is emptied before the next frame begins.

Each completed frame moves the sweep on by one frequency line. The line index runs over 200 lines by default, so a full scan lasts 60 ms. A digital ramp code that tracks the line index linearly drives the sweeping oscillator, and the same code can serve as the display's vertical deflection. A one-cycle scan-start pulse marks the cycle in which the sweep returns to line 0.

A tail-marker input locks the frame to the memory. When it is high, the next cycle becomes frame position 0, so a new integration frame starts at once after the tail of the memory passes.

Top module: `scan_quench_sequencer`

## Requirements
- R1: While the reset is low, and in the first cycle after it is released, the sample strobe, quench strobe, line index, ramp code and scan-start pulse are all 0. The first frame starts at position 0 in the first cycle after release.
- R2: The sample strobe is high for exactly one cycle per frame, at frame position PERIOD_CYC-QUENCH_CYC-1 (597 by default). It is never high together with the quench strobe.
- R3: The quench strobe is high at frame positions PERIOD_CYC-QUENCH_CYC through PERIOD_CYC-1. These are the QUENCH_CYC cycles that follow the sample cycle directly.
- R4: The line index rises by 1 at the clock edge that ends frame position PERIOD_CYC-1. It wraps from NUM_LINES-1 to 0, and it changes at no other time.
- R5: The scan-start pulse is high for exactly one cycle: the first cycle in which the line index reads 0 after a wrap. It is not raised when the block leaves reset.
- R6: Without tail-marker pulses, a frame lasts PERIOD_CYC cycles. Successive scan-start pulses are therefore NUM_LINES*PERIOD_CYC cycles apart, which is 120000 cycles (60 ms) by default.
- R7: The ramp code always equals the line index times STEP, where STEP = floor((2^RAMP_W-1)/(NUM_LINES-1)). It returns to 0 in the same cycle as the line index.
- R8: A high tail-marker in any cycle makes the next cycle frame position 0. If that cycle was not position PERIOD_CYC-1, the partial frame is abandoned: no sample and no quench are issued for it, and the line index keeps its value.
- R9: A tail-marker that arrives on the sample cycle or during the quench suppresses the rest of the quench and any line advance. A tail-marker that arrives on position PERIOD_CYC-1 behaves exactly like a normal frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock (2 MHz by default) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| tail_sync_i | input | 1 | Memory tail marker; the next cycle becomes frame position 0 |
| sample_stb_o | output | 1 | One-cycle strobe on the last integration cycle |
| quench_stb_o | output | 1 | Integrator quench, QUENCH_CYC cycles after the sample |
| line_idx_o | output | $clog2(NUM_LINES) | Current frequency line, 0 to NUM_LINES-1 |
| ramp_code_o | output | RAMP_W | Sweep oscillator code, line index times STEP |
| scan_start_o | output | 1 | One-cycle pulse when the sweep wraps to line 0 |

## Verification
A frame counter that is off by even one position shows up in the first frame: the sample strobe lands on the wrong cycle, and the quench edges move with it. Over later frames the error builds into a shift in the scan-start spacing. A line or ramp register that skips or sticks shows up at the next frame end, because the ramp code no longer equals line times STEP, or the wrap comes a frame early or late. Tail-marker handling is the easiest part to get wrong without noticing. It is therefore driven at each interesting frame position (mid-integration, sample, quench, last cycle, back-to-back). The strobes and the line index are then compared in the very next cycle.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef struct packed {
    logic sample;
    logic quench;
    logic frame_end;
  } frame_evt_t;

  function automatic int ramp_step(input int ramp_w, input int lines);
    if (lines > 1) return ((1 << ramp_w) - 1) / (lines - 1);
    return 0;
  endfunction

endpackage

// File: rtl/scan_period_timer.sv
module scan_period_timer
  import scan_seq_pkg::*;
#(
  parameter int PERIOD_CYC = 600,
  parameter int QUENCH_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  output frame_evt_t evt_o
);
  localparam int POS_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [POS_W-1:0] LAST_POS   = POS_W'(PERIOD_CYC - 1);
  localparam logic [POS_W-1:0] SAMPLE_POS = POS_W'(PERIOD_CYC - QUENCH_CYC - 1);
  localparam logic [POS_W-1:0] QUENCH_POS = POS_W'(PERIOD_CYC - QUENCH_CYC);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             at_last;

  always_comb begin
    at_last = (pos_q == LAST_POS);
    if (sync_i || at_last) pos_d = '0;
    else                   pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  always_comb begin
    evt_o.sample    = (pos_q == SAMPLE_POS);
    evt_o.quench    = (pos_q >= QUENCH_POS);
    evt_o.frame_end = at_last;
  end

  // R2 / R3: sample is followed by quench unless the tail marker restarts the frame
  assert_sample_then_quench_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o.sample && !sync_i) |=> evt_o.quench);
  assert_strobe_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o.sample && evt_o.quench));
  assert_pos_in_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= LAST_POS);
  assert_sync_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (!evt_o.sample && !evt_o.quench && !evt_o.frame_end));
endmodule

// File: rtl/scan_line_stepper.sv
module scan_line_stepper #(
  parameter int NUM_LINES = 200,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [LINE_W-1:0] line_o,
  output logic              wrap_o,
  output logic              scan_start_o
);
  localparam logic [LINE_W-1:0] TOP_LINE = LINE_W'(NUM_LINES - 1);

  logic [LINE_W-1:0] line_q, line_d;
  logic              line_en;
  logic              scan_q, scan_d;

  always_comb begin
    line_en = adv_i;
    wrap_o  = adv_i && (line_q == TOP_LINE);
    line_d  = (line_q == TOP_LINE) ? '0 : line_q + 1'b1;
    scan_d  = wrap_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      scan_q <= 1'b0;
    end else begin
      if (line_en) line_q <= line_d;
      scan_q <= scan_d;
    end
  end

  assign line_o       = line_q;
  assign scan_start_o = scan_q;

  assert_line_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o <= TOP_LINE);
  assert_line_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(line_o));
  assert_scan_on_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_start_o |-> (line_o == '0));
  assert_scan_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_start_o |=> !scan_start_o);
endmodule

// File: rtl/scan_ramp_gen.sv
module scan_ramp_gen
  import scan_seq_pkg::*;
#(
  parameter int NUM_LINES = 200,
  parameter int RAMP_W    = 12,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              wrap_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [RAMP_W-1:0] ramp_o
);
  localparam int STEP = ramp_step(RAMP_W, NUM_LINES);

  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic              ramp_en;

  always_comb begin
    ramp_en = adv_i;
    if (wrap_i) ramp_d = '0;
    else        ramp_d = ramp_q + RAMP_W'(STEP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ramp_q <= '0;
    else if (ramp_en) ramp_q <= ramp_d;
  end

  assign ramp_o = ramp_q;

  // R7: the accumulated ramp stays locked to the separately counted line index
  assert_ramp_tracks_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ramp_o) == int'(line_i) * STEP);
endmodule

// File: rtl/scan_quench_sequencer.sv
module scan_quench_sequencer
  import scan_seq_pkg::*;
#(
  parameter int PERIOD_CYC = 600,
  parameter int QUENCH_CYC = 2,
  parameter int NUM_LINES  = 200,
  parameter int RAMP_W     = 12,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tail_sync_i,
  output logic              sample_stb_o,
  output logic              quench_stb_o,
  output logic [LINE_W-1:0] line_idx_o,
  output logic [RAMP_W-1:0] ramp_code_o,
  output logic              scan_start_o
);
  frame_evt_t evt;
  logic       wrap;

  scan_period_timer #(
    .PERIOD_CYC(PERIOD_CYC),
    .QUENCH_CYC(QUENCH_CYC)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(tail_sync_i),
    .evt_o (evt)
  );

  scan_line_stepper #(
    .NUM_LINES(NUM_LINES)
  ) u_lines (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (evt.frame_end),
    .line_o      (line_idx_o),
    .wrap_o      (wrap),
    .scan_start_o(scan_start_o)
  );

  scan_ramp_gen #(
    .NUM_LINES(NUM_LINES),
    .RAMP_W   (RAMP_W)
  ) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (evt.frame_end),
    .wrap_i(wrap),
    .line_i(line_idx_o),
    .ramp_o(ramp_code_o)
  );

  assign sample_stb_o = evt.sample;
  assign quench_stb_o = evt.quench;

  // R9: an abandoned frame never moves the sweep
  assert_no_advance_on_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_sync_i && !evt.frame_end) |=> $stable(line_idx_o));
  // R4: the sweep moves only on the cycle after a quench
  assert_advance_after_quench_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quench_stb_o |=> $stable(line_idx_o));
endmodule

// File: tb/test_scan_quench_sequencer.sv
module test_scan_quench_sequencer;
  localparam int P     = 16;
  localparam int Q     = 2;
  localparam int L     = 6;
  localparam int W     = 8;
  localparam int LW    = $clog2(L);
  localparam int STEP  = ((1 << W) - 1) / (L - 1);
  localparam int SPOS  = P - Q - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync = 1'b0;
  logic          samp, quen, scan;
  logic [LW-1:0] line;
  logic [W-1:0]  ramp;

  always #10 clk = ~clk;

  scan_quench_sequencer #(
    .PERIOD_CYC(P), .QUENCH_CYC(Q), .NUM_LINES(L), .RAMP_W(W)
  ) i_scan_quench_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .tail_sync_i(sync),
    .sample_stb_o(samp), .quench_stb_o(quen), .line_idx_o(line),
    .ramp_code_o(ramp), .scan_start_o(scan)
  );

  typedef struct {
    bit    s;
    bit    q;
    int    ln;
    int    rp;
    bit    sc;
    bit    syn;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    m_pos = 0;
  int    m_line = 0;
  bit    m_scan = 0;
  bit    done = 0;
  string cur_tag = "R2";

  task automatic cmp(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one call per cycle, pushes the expected outputs of that cycle
  task automatic cyc(input bit s);
    exp_t e;
    bit   adv;
    @(negedge clk);
    rst_n = 1'b1;
    sync  = s;
    e.s   = (m_pos == SPOS);
    e.q   = (m_pos >= P - Q);
    e.ln  = m_line;
    e.rp  = m_line * STEP;
    e.sc  = m_scan;
    e.syn = s;
    e.tag = cur_tag;
    sb.push_back(e);
    adv    = (m_pos == P - 1);
    m_scan = adv && (m_line == L - 1);
    if (adv) m_line = (m_line == L - 1) ? 0 : m_line + 1;
    m_pos  = (s || adv) ? 0 : m_pos + 1;
  endtask

  task automatic run_to(input int pos);
    while (m_pos != pos) cyc(1'b0);
  endtask

  // monitor
  int mon_cyc = 0;
  int last_scan = 0;
  bit scan_ok = 1;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp({e.tag, "/R2 sample"}, samp, e.s);
        cmp({e.tag, "/R3 quench"}, quen, e.q);
        cmp({e.tag, "/R4 line"},   line, e.ln);
        cmp({e.tag, "/R7 ramp"},   ramp, e.rp);
        cmp({e.tag, "/R5 scan"},   scan, e.sc);
        if (scan) begin
          if (scan_ok) cmp("R6 scan spacing", mon_cyc - last_scan, L * P);
          last_scan = mon_cyc;
          scan_ok   = 1;
        end
        if (e.syn) scan_ok = 0;
        mon_cyc++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    cmp("R1 reset sample", samp, 0);
    cmp("R1 reset quench", quen, 0);
    cmp("R1 reset line", line, 0);
    cmp("R1 reset ramp", ramp, 0);
    cmp("R1 reset scan", scan, 0);
    // R1 / R2 / R3 / R4 / R5 / R6 / R7: free run over three scans
    cur_tag = "R1";
    cyc(1'b0);
    cur_tag = "R6";
    repeat (3 * L * P) cyc(1'b0);
    // R8: tail marker mid-integration
    cur_tag = "R8";
    run_to(5);
    cyc(1'b1);
    repeat (P + 3) cyc(1'b0);
    // R9: tail marker on the sample cycle
    cur_tag = "R9";
    run_to(SPOS);
    cyc(1'b1);
    repeat (4) cyc(1'b0);
    // R9: tail marker during the quench
    run_to(P - Q);
    cyc(1'b1);
    repeat (4) cyc(1'b0);
    // R9: tail marker on the last position, aligned boundary
    run_to(P - 1);
    cyc(1'b1);
    repeat (P) cyc(1'b0);
    // R8: back-to-back markers
    cur_tag = "R8";
    repeat (3) cyc(1'b1);
    repeat (2 * P) cyc(1'b0);
    // aligned markers every frame, crossing a wrap
    cur_tag = "R9";
    for (int k = 0; k < L + 2; k++) begin
      run_to(P - 1);
      cyc(1'b1);
    end
    repeat (P) cyc(1'b0);
    @(negedge clk);
    #5;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule